// File: doc/BRIEF.md
# External Bus Master with Per-Region Port Sizing

This block sits between an on-chip requester and an external memory bus with asynchronous-style handshaking. The requester hands over one 32-bit read or write at a time through a valid/ready pair. The block compares the address against eight programmable regions. Each region has a base and a mask, an enable bit and a port width. The winning region's chip select is driven for the whole access.

When the region's port is narrower than 32 bits, the access is split into two or four beats. The beats go out in order of ascending byte address. Narrow data travels on the most significant byte lanes of the bus. Read bytes are assembled big-endian, so the first beat fills the top of the word. Each beat opens with a one-cycle start pulse and stays on the bus until the slave returns a normal or an error acknowledge.

After reset, region 0 is enabled and matches every address, so boot code can run. Its width comes from two strap inputs, which are sampled while reset is held. All other regions start disabled and must be programmed before use. The requester receives a one-cycle response carrying the assembled read data and an error flag.

Top module: `xbus_master`

## Requirements
- R1: While reset is high and in the first cycle after it, req_ready is 1, and bus_busy, bus_start, rsp_valid and all bus_cs bits are 0.
- R2: Region i matches when it is enabled and ((addr ^ base) & mask) == 0. Among the matching regions, the one with the highest index wins. During every beat, bus_cs is one-hot with bit i set for the winning region. bus_cs is all zero outside a transfer.
- R3: The port width code is 2'b01 for 8 bits (4 beats), 2'b10 for 16 bits (2 beats), and 2'b00 or 2'b11 for 32 bits (1 beat).
- R4: Reset leaves region 0 enabled with base 0, mask 0 and the width code taken from strap_width. Regions 1 and up are left disabled.
- R5: bus_start is high for exactly the first cycle of each beat. bus_busy is high from the first beat's start until the cycle in which the final acknowledge is taken.
- R6: bus_rnw is 1 for a read and 0 for a write. bus_addr, bus_cs and bus_rnw stay stable while a beat waits for its acknowledge.
- R7: Beat k addresses {addr[31:2],2'b00} + k*B, where B is the port width in bytes. Write and read bytes of that beat travel on bus lanes [31:32-8B]. Word byte k*B sits at bits [31:24], so the first beat carries the most significant bytes.
- R8: A normal acknowledge (bus_ack) on a read captures the beat's lanes into the result. The acknowledge on the last beat ends the access. rsp_valid rises in the next cycle with rsp_err 0.
- R9: An error acknowledge (bus_err) ends the access in that cycle. No further beat starts, and the response carries rsp_err 1. bus_err wins when bus_ack is high in the same cycle.
- R10: An address that no enabled region matches gets rsp_err 1 without any bus_start.
- R11: Only one access is outstanding. req_ready is 1 only when idle, and rsp_valid is a single-cycle pulse during which req_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strap_width | input | 2 | Region 0 width code, sampled during reset |
| cfg_we | input | 1 | Write one region's settings |
| cfg_idx | input | 3 | Region index to write |
| cfg_en | input | 1 | Region enable |
| cfg_base | input | 32 | Region base address |
| cfg_mask | input | 32 | Region compare mask |
| cfg_pw | input | 2 | Region width code |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Request byte address |
| req_wdata | input | 32 | Write word |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 32 | Assembled read word |
| rsp_err | output | 1 | Access error |
| bus_start | output | 1 | Beat start pulse |
| bus_busy | output | 1 | Transfer in progress |
| bus_rnw | output | 1 | 1 = read from slave, 0 = write |
| bus_cs | output | 8 | Chip selects, active high |
| bus_addr | output | 32 | Beat byte address |
| bus_wdata | output | 32 | Beat write data |
| bus_rdata | input | 32 | Slave read data |
| bus_ack | input | 1 | Normal acknowledge |
| bus_err | input | 1 | Error acknowledge |

## Verification
The bench drives every width through reads and writes, with regions that overlap region 0. A priority or lane bug would show up as the wrong chip select, a reversed byte order, or bytes taken from the unused low lanes. The bench injects an error on a middle beat and also raises both acknowledges together. A design that kept going after the error, or let the normal acknowledge win, would issue extra beats or report success. The bench resets with each strap code to catch a swapped width encoding for the boot region. It also disables region 0 so that a design sending unmapped accesses onto the bus would show a start pulse.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        PW_32A = 2'b00,
        PW_8   = 2'b01,
        PW_16  = 2'b10,
        PW_32B = 2'b11
    } pw_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_RESP = 2'd2
    } st_e;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] mask;
        pw_e               pw;
    } region_t;

    function automatic logic [2:0] beats_of(pw_e pw);
        case (pw)
            PW_8:    return 3'd4;
            PW_16:   return 3'd2;
            default: return 3'd1;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] top_lanes(pw_e pw);
        case (pw)
            PW_8:    return 32'hFF00_0000;
            PW_16:   return 32'hFFFF_0000;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/xbus_region_file.sv
module xbus_region_file
    import xbus_pkg::*;
#(
    parameter int NCS = 8,
    localparam int IW = $clog2(NCS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        strap_width,
    input  logic              cfg_we,
    input  logic [IW-1:0]     cfg_idx,
    input  logic              cfg_en,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_mask,
    input  logic [1:0]        cfg_pw,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [NCS-1:0]    lk_cs,
    output pw_e               lk_pw
);

    region_t          regs  [NCS];
    logic [NCS-1:0]   match;

    for (genvar i = 0; i < NCS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                if (i == 0) regs[i] <= '{en: 1'b1, base: '0, mask: '0, pw: pw_e'(strap_width)};
                else        regs[i] <= '{en: 1'b0, base: '0, mask: '0, pw: PW_32A};
            end else if (cfg_we && cfg_idx == IW'(i)) begin
                regs[i] <= '{en: cfg_en, base: cfg_base, mask: cfg_mask, pw: pw_e'(cfg_pw)};
            end
        end
        assign match[i] = regs[i].en && (((lk_addr ^ regs[i].base) & regs[i].mask) == '0);
    end

    // Highest matching index wins: later iterations override earlier ones.
    always_comb begin
        lk_hit = 1'b0;
        lk_cs  = '0;
        lk_pw  = PW_32A;
        for (int i = 0; i < NCS; i++) begin
            if (match[i]) begin
                lk_hit = 1'b1;
                lk_cs  = NCS'(1) << i;
                lk_pw  = regs[i].pw;
            end
        end
    end

    a_r2_winner_onehot: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> $countones(lk_cs) == 1);

    a_r4_boot_region_live: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (lk_hit && lk_cs[0]) || (lk_cs != '0 && !lk_cs[0]));

endmodule

// File: rtl/xbus_lanes.sv
module xbus_lanes
    import xbus_pkg::*;
(
    input  pw_e               pw,
    input  logic [1:0]        beat,
    input  logic [DATA_W-1:0] word,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] lane_rdata,
    output logic [1:0]        byte_off,
    output logic [DATA_W-1:0] lane_wdata,
    output logic [DATA_W-1:0] acc_out
);

    logic [4:0]        shamt;
    logic [DATA_W-1:0] keep;

    always_comb begin
        case (pw)
            PW_8:    byte_off = beat;
            PW_16:   byte_off = {beat[0], 1'b0};
            default: byte_off = 2'd0;
        endcase
        shamt      = {byte_off, 3'b000};
        lane_wdata = word << shamt;
        keep       = top_lanes(pw) >> shamt;
        acc_out    = (acc_in & ~keep) | ((lane_rdata & top_lanes(pw)) >> shamt);
    end

endmodule

// File: rtl/xbus_beat_seq.sv
module xbus_beat_seq
    import xbus_pkg::*;
#(
    parameter int NCS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              lk_hit,
    input  logic [NCS-1:0]    lk_cs,
    input  pw_e               lk_pw,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              bus_start,
    output logic              bus_busy,
    output logic              bus_rnw,
    output logic [NCS-1:0]    bus_cs,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack,
    input  logic              bus_err
);

    st_e                st;
    logic [1:0]         beat;
    logic               first;
    logic               rnw_q;
    logic [NCS-1:0]     cs_q;
    pw_e                pw_q;
    logic [ADDR_W-3:0]  wa_q;
    logic [DATA_W-1:0]  wd_q;
    logic [DATA_W-1:0]  acc_q;
    logic [DATA_W-1:0]  acc_nx;
    logic               err_q;
    logic [1:0]         off;
    logic               last_beat;

    xbus_lanes u_lanes (
        .pw         (pw_q),
        .beat       (beat),
        .word       (wd_q),
        .acc_in     (acc_q),
        .lane_rdata (bus_rdata),
        .byte_off   (off),
        .lane_wdata (bus_wdata),
        .acc_out    (acc_nx)
    );

    assign last_beat = ({1'b0, beat} == beats_of(pw_q) - 3'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            beat  <= '0;
            first <= 1'b0;
            rnw_q <= 1'b1;
            cs_q  <= '0;
            pw_q  <= PW_32A;
            wa_q  <= '0;
            wd_q  <= '0;
            acc_q <= '0;
            err_q <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (req_valid) begin
                    beat  <= '0;
                    first <= 1'b1;
                    rnw_q <= !req_write;
                    cs_q  <= lk_cs;
                    pw_q  <= lk_pw;
                    wa_q  <= req_addr[ADDR_W-1:2];
                    wd_q  <= req_wdata;
                    acc_q <= '0;
                    err_q <= !lk_hit;
                    st    <= lk_hit ? ST_RUN : ST_RESP;
                end
                ST_RUN: begin
                    first <= 1'b0;
                    if (bus_err) begin
                        err_q <= 1'b1;
                        st    <= ST_RESP;
                    end else if (bus_ack) begin
                        if (rnw_q) acc_q <= acc_nx;
                        if (last_beat) begin
                            st <= ST_RESP;
                        end else begin
                            beat  <= beat + 2'd1;
                            first <= 1'b1;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (st == ST_IDLE);
    assign bus_busy  = (st == ST_RUN);
    assign bus_start = (st == ST_RUN) && first;
    assign bus_cs    = (st == ST_RUN) ? cs_q : '0;
    assign bus_rnw   = (st == ST_RUN) ? rnw_q : 1'b1;
    assign bus_addr  = {wa_q, 2'b00} + ADDR_W'(off);
    assign rsp_valid = (st == ST_RESP);
    assign rsp_rdata = acc_q;
    assign rsp_err   = err_q;

    a_r5_start_inside_busy: assert property (@(posedge clk) disable iff (rst)
        bus_start |-> bus_busy);

    a_r2_cs_onehot_in_beat: assert property (@(posedge clk) disable iff (rst)
        bus_busy |-> $countones(bus_cs) == 1);

    a_r2_cs_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !bus_busy |-> bus_cs == '0);

    a_r6_hold_while_waiting: assert property (@(posedge clk) disable iff (rst)
        (bus_busy && !bus_ack && !bus_err) |=>
            (bus_busy && !bus_start && $stable(bus_addr) && $stable(bus_cs) && $stable(bus_rnw)));

    a_r9_error_ends_now: assert property (@(posedge clk) disable iff (rst)
        (bus_busy && bus_err) |=> (!bus_busy && rsp_valid && rsp_err));

    a_r11_resp_not_ready: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    a_r11_resp_single: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/xbus_master.sv
module xbus_master
    import xbus_pkg::*;
#(
    parameter int NCS = 8,
    localparam int IW = $clog2(NCS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        strap_width,
    input  logic              cfg_we,
    input  logic [IW-1:0]     cfg_idx,
    input  logic              cfg_en,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_mask,
    input  logic [1:0]        cfg_pw,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              bus_start,
    output logic              bus_busy,
    output logic              bus_rnw,
    output logic [NCS-1:0]    bus_cs,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack,
    input  logic              bus_err
);

    logic           lk_hit;
    logic [NCS-1:0] lk_cs;
    pw_e            lk_pw;

    xbus_region_file #(.NCS(NCS)) u_regions (
        .clk         (clk),
        .rst         (rst),
        .strap_width (strap_width),
        .cfg_we      (cfg_we),
        .cfg_idx     (cfg_idx),
        .cfg_en      (cfg_en),
        .cfg_base    (cfg_base),
        .cfg_mask    (cfg_mask),
        .cfg_pw      (cfg_pw),
        .lk_addr     (req_addr),
        .lk_hit      (lk_hit),
        .lk_cs       (lk_cs),
        .lk_pw       (lk_pw)
    );

    xbus_beat_seq #(.NCS(NCS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .lk_hit    (lk_hit),
        .lk_cs     (lk_cs),
        .lk_pw     (lk_pw),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_err   (rsp_err),
        .bus_start (bus_start),
        .bus_busy  (bus_busy),
        .bus_rnw   (bus_rnw),
        .bus_cs    (bus_cs),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ack   (bus_ack),
        .bus_err   (bus_err)
    );

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && !bus_busy && !bus_start && !rsp_valid && bus_cs == '0));

endmodule

// File: tb/test_xbus_master.sv
module test_xbus_master;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  strap_width = 2'b00;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic        cfg_en = 1'b0;
    logic [31:0] cfg_base = '0, cfg_mask = '0;
    logic [1:0]  cfg_pw = '0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_ready, rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        bus_start, bus_busy, bus_rnw;
    logic [7:0]  bus_cs;
    logic [31:0] bus_addr, bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_ack = 1'b0, bus_err = 1'b0;

    always #2 clk = ~clk;

    xbus_master i_xbus_master (
        .clk(clk), .rst(rst), .strap_width(strap_width),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en), .cfg_base(cfg_base),
        .cfg_mask(cfg_mask), .cfg_pw(cfg_pw),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .bus_start(bus_start), .bus_busy(bus_busy), .bus_rnw(bus_rnw), .bus_cs(bus_cs),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .bus_err(bus_err)
    );

    int n_chk = 0, n_bad = 0;
    int cycles = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Slave model and its expectations
    logic [7:0]  mem [256];
    logic [31:0] exp_base;
    int          exp_wb = 4;
    logic [7:0]  exp_cs;
    logic        exp_rnw;
    int          err_beat = -1;
    bit          err_both = 0;
    int          waits = 0;
    int          starts = 0, beats = 0, addr_bad = 0, cs_bad = 0, rnw_bad = 0, rdy_seen = 0, rsp_cnt = 0;
    int          wcnt = 0;

    function automatic logic [7:0] patt(input logic [31:0] a);
        return a[7:0] * 8'd7 + 8'd11;
    endfunction

    always @(negedge clk) begin
        cycles++;
        if (rsp_valid) rsp_cnt++;
        if (bus_busy && req_ready) rdy_seen++;
        if (bus_start) starts++;
        bus_ack   <= 1'b0;
        bus_err   <= 1'b0;
        bus_rdata <= 32'hEEEE_EEEE;
        if (bus_busy) begin
            if (bus_start) wcnt = 0; else wcnt++;
            if (wcnt >= waits) begin
                logic [31:0] rd;
                rd = 32'hEEEE_EEEE;
                if (bus_addr != exp_base + 32'(beats * exp_wb)) addr_bad++;
                if (bus_cs != exp_cs) cs_bad++;
                if (bus_rnw != exp_rnw) rnw_bad++;
                for (int j = 0; j < exp_wb; j++) begin
                    rd[31-8*j -: 8] = patt(bus_addr + 32'(j));
                    if (!bus_rnw) mem[8'(bus_addr + 32'(j))] = bus_wdata[31-8*j -: 8];
                end
                bus_rdata <= rd;
                if (beats == err_beat) begin
                    bus_err <= 1'b1;
                    bus_ack <= err_both;
                end else begin
                    bus_ack <= 1'b1;
                end
                beats++;
            end
        end
    end

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    task automatic do_reset(input logic [1:0] strap);
        @(negedge clk);
        rst = 1'b1;
        strap_width = strap;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic set_region(input int idx, input bit en, input logic [31:0] base,
                              input logic [31:0] mask, input logic [1:0] pw);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_en = en;
        cfg_base = base; cfg_mask = mask; cfg_pw = pw;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(input bit wr, input logic [31:0] addr, input logic [31:0] wd,
                          input int wb, input int csi, input int eb, input bit both, input int w,
                          output logic [31:0] rd, output logic err);
        int guard;
        @(negedge clk);
        exp_base = {addr[31:2], 2'b00};
        exp_wb = wb;
        exp_cs = 8'(1) << csi;
        exp_rnw = !wr;
        err_beat = eb; err_both = both; waits = w;
        starts = 0; beats = 0; addr_bad = 0; cs_bad = 0; rnw_bad = 0; rdy_seen = 0; rsp_cnt = 0;
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (!rsp_valid && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        rd = rsp_rdata;
        err = rsp_err;
        @(negedge clk);
        @(negedge clk);
        if (guard >= 200) chk(0, "R8 response timeout", 32'(guard), 0);
    endtask

    function automatic logic [31:0] exp_word(input logic [31:0] a);
        logic [31:0] b;
        b = {a[31:2], 2'b00};
        return {patt(b), patt(b + 1), patt(b + 2), patt(b + 3)};
    endfunction

    // {write, addr, wdata}
    localparam logic [64:0] VEC [8] = '{
        {1'b0, 32'h0000_0040, 32'h0},
        {1'b1, 32'h1000_0080, 32'hDEAD_BEEF},
        {1'b0, 32'h1000_0084, 32'h0},
        {1'b1, 32'h2000_00C0, 32'hCAFE_1234},
        {1'b0, 32'h2000_00C8, 32'h0},
        {1'b1, 32'h3000_0010, 32'h0BAD_F00D},
        {1'b0, 32'h3000_0014, 32'h0},
        {1'b1, 32'h0000_0020, 32'h1357_9BDF}
    };

    initial begin
        logic [31:0] rd;
        logic        er;
        int          rwb [4];
        rwb = '{4, 1, 2, 4};

        do_reset(2'b00);
        @(negedge clk);
        chk(req_ready === 1'b1, "R1 ready after reset", 32'(req_ready), 1);
        chk(bus_busy === 1'b0 && bus_start === 1'b0, "R1 bus quiet", {bus_busy, bus_start}, 0);
        chk(bus_cs === 8'h00, "R1 cs low", 32'(bus_cs), 0);
        chk(rsp_valid === 1'b0, "R1 no response", 32'(rsp_valid), 0);

        set_region(1, 1, 32'h1000_0000, 32'hF000_0000, 2'b01);
        set_region(2, 1, 32'h2000_0000, 32'hF000_0000, 2'b10);
        set_region(3, 1, 32'h3000_0000, 32'hF000_0000, 2'b11);

        foreach (VEC[i]) begin
            bit          wr;
            logic [31:0] a, wd;
            int          reg_i, wb;
            {wr, a, wd} = VEC[i];
            reg_i = int'(a[29:28]);
            wb = rwb[reg_i];
            access(wr, a, wd, wb, reg_i, -1, 0, i % 3, rd, er);
            chk(er === 1'b0, $sformatf("R8 vec%0d no error", i), 32'(er), 0);
            chk(beats == 4 / wb, $sformatf("R3 vec%0d beats", i), 32'(beats), 32'(4 / wb));
            chk(starts == beats, $sformatf("R5 vec%0d one start per beat", i), 32'(starts), 32'(beats));
            chk(addr_bad == 0, $sformatf("R7 vec%0d beat addresses", i), 32'(addr_bad), 0);
            chk(cs_bad == 0, $sformatf("R2 vec%0d chip select", i), 32'(cs_bad), 0);
            chk(rnw_bad == 0, $sformatf("R6 vec%0d direction", i), 32'(rnw_bad), 0);
            chk(rdy_seen == 0 && rsp_cnt == 1, $sformatf("R11 vec%0d handshake", i),
                32'(rdy_seen * 16 + rsp_cnt), 1);
            if (wr) begin
                logic [31:0] got;
                logic [31:0] b;
                b = {a[31:2], 2'b00};
                got = {mem[8'(b)], mem[8'(b + 1)], mem[8'(b + 2)], mem[8'(b + 3)]};
                chk(got === wd, $sformatf("R7 vec%0d write lanes", i), got, wd);
            end else begin
                chk(rd === exp_word(a), $sformatf("R8 vec%0d read assembly", i), rd, exp_word(a));
            end
        end

        // R9: error on the second of four beats
        access(0, 32'h1000_0100, 0, 1, 1, 1, 0, 1, rd, er);
        chk(er === 1'b1, "R9 error reported", 32'(er), 1);
        chk(beats == 2 && starts == 2, "R9 remaining beats dropped", 32'(beats * 16 + starts), 32'h22);

        // R9: both acknowledges together, error wins
        access(0, 32'h2000_0100, 0, 2, 2, 0, 1, 0, rd, er);
        chk(er === 1'b1, "R9 error beats ack", 32'(er), 1);
        chk(starts == 1, "R9 no second beat", 32'(starts), 1);

        // R4 / R3: boot region width from straps
        for (int s = 0; s < 4; s++) begin
            int ewb;
            ewb = (s == 1) ? 1 : (s == 2) ? 2 : 4;
            do_reset(2'(s));
            access(0, 32'h5000_0060, 0, ewb, 0, -1, 0, 0, rd, er);
            chk(beats == 4 / ewb, $sformatf("R4 strap %0d beats", s), 32'(beats), 32'(4 / ewb));
            chk(rd === exp_word(32'h5000_0060) && er === 1'b0,
                $sformatf("R4 strap %0d data", s), rd, exp_word(32'h5000_0060));
            access(0, 32'h1000_0000, 0, ewb, 0, -1, 0, 0, rd, er);
            chk(cs_bad == 0, $sformatf("R4 strap %0d other regions off", s), 32'(cs_bad), 0);
        end

        // R10: unmapped address
        set_region(0, 0, 32'h0, 32'h0, 2'b00);
        access(0, 32'h7000_0000, 0, 4, 0, -1, 0, 0, rd, er);
        chk(er === 1'b1, "R10 unmapped error", 32'(er), 1);
        chk(starts == 0, "R10 no bus cycle", 32'(starts), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule